// File: doc/BRIEF.md
# SMBus Slave Address Recognition Unit

This block listens on a two-wire SMBus/I2C bus as a receiving slave. It samples SCL and SDA with the system clock and detects START and STOP conditions. After each START it shifts in the first byte and compares its seven address bits with a programmed slave address. A per-bit mask selects which address bits must agree. The general call address can also be accepted when automatic acknowledgement is on.

Two configuration registers are written through simple write strobes, and their contents can be read back. The address register holds the slave address and the general-call enable. The mask register holds the compare mask and the hardware-acknowledge enable. With hardware acknowledge on, the block pulls SDA low in the ninth clock for a matching address and for every data byte that follows. With it off, each byte is reported as a one-cycle event, and an external ack/nack input decides the acknowledge. After a byte that is not acknowledged, the block ignores the bus until the next START or STOP. Clock stretching, transmitting and master operation are not part of this block.

Top module: `smb_slave_addr_rx`

## Requirements
- R1: After reset, the address register reads 0x00 and the mask register reads 0xFE: all compare bits are 1 and hardware acknowledge is off. SDA is not driven.
- R2: Address register bits 7:1 hold the slave address and mask register bits 7:1 hold the compare mask. Bits 7:1 of the received address byte must equal the slave address only where the mask bit is 1. The event match flag reports the outcome.
- R3: An address byte whose bits 7:1 are all zero also matches when address register bit 0 (general-call enable) and mask register bit 0 (hardware acknowledge) are both 1. When either of them is 0, it matches only through the masked compare.
- R4: With mask register bit 0 set, a matching address byte is acknowledged automatically and a non-matching one is not.
- R5: With mask register bit 0 set, every data byte that follows an acknowledged address is acknowledged automatically.
- R6: In either mode, each byte received in an active transfer raises `evt_o` for one cycle. The event carries the byte value and a flag that marks an address byte. With mask register bit 0 clear, a byte is acknowledged exactly when `sw_ack_i` is high at the SCL falling edge that ends its eighth bit.
- R7: After a byte that was not acknowledged, the block raises no event and drives no SDA until the next START or STOP.
- R8: A START (SDA falling while SCL is high) returns the block to address reception. This also holds for a repeated START. A STOP (SDA rising while SCL is high) does the same.
- R9: Bits arrive MSB first on SCL rising edges. Bit 0 of the address byte is the read/write flag and takes no part in the compare.
- R10: SDA is pulled low only from the SCL falling edge after the eighth bit to the SCL falling edge after the ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| cfg_we_addr_i | input | 1 | Write strobe for the address register |
| cfg_we_mask_i | input | 1 | Write strobe for the mask register |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_addr_o | output | 8 | Address register contents |
| cfg_mask_o | output | 8 | Mask register contents |
| sw_ack_i | input | 1 | External acknowledge decision, 1 = ACK |
| evt_o | output | 1 | One-cycle pulse: a byte was received |
| evt_byte_o | output | 8 | Value of the last received byte |
| evt_is_addr_o | output | 1 | The last received byte was an address byte |
| evt_match_o | output | 1 | The address compare result of the last byte |

## Verification
A bus edge reaches the outputs three system clocks later: two synchroniser stages plus the output register. The bench holds every bus phase for at least six clocks. It reads the acknowledge level halfway through the ninth SCL high phase, and it reads the SDA drive six clocks after each SCL falling edge, so every result is settled before it is sampled. The byte event lasts only one cycle, so a monitor on the falling clock edge counts the pulses and latches the byte fields. Each check then compares these counts and fields with the values expected for the byte just sent. `sw_ack_i` is set before a byte starts, so it is stable at the falling edge that ends the eighth bit.

// File: rtl/smb_addr_pkg.sv
package smb_addr_pkg;

   typedef enum logic [1:0] {
      RX_IGNORE = 2'd0,
      RX_SHIFT  = 2'd1,
      RX_DECIDE = 2'd2,
      RX_ACKSLT = 2'd3
   } rx_state_e;

endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   logic [STAGES-1:0] scl_q;
   logic [STAGES-1:0] sda_q;
   logic              scl_prev;
   logic              sda_prev;
   logic              scl_s;
   logic              sda_s;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q <= '1;
               sda_q <= '1;
            end else begin
               scl_q <= scl_i;
               sda_q <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q <= '1;
               sda_q <= '1;
            end else begin
               scl_q <= {scl_q[STAGES-2:0], scl_i};
               sda_q <= {sda_q[STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   assign scl_s = scl_q[STAGES-1];
   assign sda_s = sda_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   assign sda_o      = sda_s;
   assign scl_rise_o = scl_s & ~scl_prev;
   assign scl_fall_o = ~scl_s & scl_prev;
   assign start_o    = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_o     = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/smb_addr_regs.sv
module smb_addr_regs #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_addr_i,
   input  logic              we_mask_i,
   input  logic [ADDR_W:0]   wdata_i,
   output logic [ADDR_W-1:0] slv_o,
   output logic              gc_en_o,
   output logic [ADDR_W-1:0] mask_o,
   output logic              hw_en_o,
   output logic [ADDR_W:0]   addr_reg_o,
   output logic [ADDR_W:0]   mask_reg_o
);

   localparam logic [ADDR_W:0] ADDR_RST = '0;
   localparam logic [ADDR_W:0] MASK_RST = {{ADDR_W{1'b1}}, 1'b0};

   logic [ADDR_W:0] addr_q;
   logic [ADDR_W:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= ADDR_RST;
         mask_q <= MASK_RST;
      end else begin
         if (we_addr_i) addr_q <= wdata_i;
         if (we_mask_i) mask_q <= wdata_i;
      end
   end

   assign slv_o      = addr_q[ADDR_W:1];
   assign gc_en_o    = addr_q[0];
   assign mask_o     = mask_q[ADDR_W:1];
   assign hw_en_o    = mask_q[0];
   assign addr_reg_o = addr_q;
   assign mask_reg_o = mask_q;

   // R1: a cycle spent in reset leaves both registers at their reset values
   p_reset_vals_r1: assert property (@(posedge clk)
      !rst_n |=> (addr_reg_o == ADDR_RST && mask_reg_o == MASK_RST));

endmodule

// File: rtl/smb_addr_cmp.sv
module smb_addr_cmp #(
   parameter int ADDR_W     = 7,
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic [ADDR_W-1:0] rx_addr_i,
   input  logic [ADDR_W-1:0] slv_i,
   input  logic [ADDR_W-1:0] mask_i,
   input  logic              gc_en_i,
   input  logic              hw_en_i,
   output logic              match_o
);

   logic [ADDR_W-1:0] bit_ok;
   logic              gc_hit;

   generate
      for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
         assign bit_ok[i] = ~mask_i[i] | ~(rx_addr_i[i] ^ slv_i[i]);
      end
      if (GC_SUPPORT) begin : g_gc
         assign gc_hit = gc_en_i & hw_en_i & ~(|rx_addr_i);
      end else begin : g_no_gc
         assign gc_hit = 1'b0;
      end
   endgenerate

   assign match_o = (&bit_ok) | gc_hit;

endmodule

// File: rtl/smb_slave_addr_rx.sv
module smb_slave_addr_rx
   import smb_addr_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter bit GC_SUPPORT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   input  logic              cfg_we_addr_i,
   input  logic              cfg_we_mask_i,
   input  logic [ADDR_W:0]   cfg_wdata_i,
   output logic [ADDR_W:0]   cfg_addr_o,
   output logic [ADDR_W:0]   cfg_mask_o,
   input  logic              sw_ack_i,
   output logic              evt_o,
   output logic [ADDR_W:0]   evt_byte_o,
   output logic              evt_is_addr_o,
   output logic              evt_match_o
);

   localparam int BYTE_W = ADDR_W + 1;
   localparam int CNT_W  = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   generate
      if (ADDR_W < 1 || ADDR_W > 15) begin : g_bad_addr_w
         $error("smb_slave_addr_rx: ADDR_W must lie in 1..15");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("smb_slave_addr_rx: SYNC_STAGES must lie in 1..4");
      end
   endgenerate

   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic [ADDR_W-1:0] slv;
   logic [ADDR_W-1:0] mask;
   logic              gc_en;
   logic              hw_en;
   logic              match_now;

   smb_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det)
   );

   smb_addr_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_addr_i  (cfg_we_addr_i),
      .we_mask_i  (cfg_we_mask_i),
      .wdata_i    (cfg_wdata_i),
      .slv_o      (slv),
      .gc_en_o    (gc_en),
      .mask_o     (mask),
      .hw_en_o    (hw_en),
      .addr_reg_o (cfg_addr_o),
      .mask_reg_o (cfg_mask_o)
   );

   rx_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] shreg_q;
   logic [BYTE_W-1:0] byte_next;
   logic              is_addr_q;
   logic              ack_q;
   logic              pull_q;
   logic              ack_dec;
   logic              evt_q;
   logic [BYTE_W-1:0] evt_byte_q;
   logic              evt_addr_q;
   logic              evt_match_q;

   assign byte_next = {shreg_q[BYTE_W-2:0], sda_s};

   smb_addr_cmp #(.ADDR_W(ADDR_W), .GC_SUPPORT(GC_SUPPORT)) u_cmp (
      .rx_addr_i (byte_next[BYTE_W-1:1]),
      .slv_i     (slv),
      .mask_i    (mask),
      .gc_en_i   (gc_en),
      .hw_en_i   (hw_en),
      .match_o   (match_now)
   );

   always_comb begin
      if (hw_en) ack_dec = evt_addr_q ? evt_match_q : 1'b1;
      else       ack_dec = sw_ack_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= RX_IGNORE;
         cnt_q       <= '0;
         shreg_q     <= '0;
         is_addr_q   <= 1'b0;
         ack_q       <= 1'b0;
         pull_q      <= 1'b0;
         evt_q       <= 1'b0;
         evt_byte_q  <= '0;
         evt_addr_q  <= 1'b0;
         evt_match_q <= 1'b0;
      end else begin
         evt_q <= 1'b0;
         if (stop_det) begin
            state_q <= RX_IGNORE;
            pull_q  <= 1'b0;
         end else if (start_det) begin
            state_q   <= RX_SHIFT;
            is_addr_q <= 1'b1;
            cnt_q     <= '0;
            pull_q    <= 1'b0;
         end else begin
            unique case (state_q)
               RX_SHIFT: begin
                  if (scl_rise) begin
                     shreg_q <= byte_next;
                     if (cnt_q == LAST_BIT) begin
                        cnt_q       <= '0;
                        state_q     <= RX_DECIDE;
                        evt_q       <= 1'b1;
                        evt_byte_q  <= byte_next;
                        evt_addr_q  <= is_addr_q;
                        evt_match_q <= match_now;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               RX_DECIDE: begin
                  if (scl_fall) begin
                     pull_q  <= ack_dec;
                     ack_q   <= ack_dec;
                     state_q <= RX_ACKSLT;
                  end
               end
               RX_ACKSLT: begin
                  if (scl_fall) begin
                     pull_q <= 1'b0;
                     if (ack_q) begin
                        state_q   <= RX_SHIFT;
                        is_addr_q <= 1'b0;
                     end else begin
                        state_q <= RX_IGNORE;
                     end
                  end
               end
               default: state_q <= RX_IGNORE;
            endcase
         end
      end
   end

   assign sda_pull_o    = pull_q;
   assign evt_o         = evt_q;
   assign evt_byte_o    = evt_byte_q;
   assign evt_is_addr_o = evt_addr_q;
   assign evt_match_o   = evt_match_q;

   // R10: the acknowledge drive begins only on an SCL falling edge
   p_pull_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> $past(scl_fall));

   // R10: the drive ends on an SCL falling edge, or on a bus condition
   p_pull_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull_o) |-> $past(scl_fall || start_det || stop_det));

   // R6: a byte event follows a sampled SCL rising edge
   p_evt_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> $past(scl_rise));

   // R6: in software mode the drive follows the external decision
   p_sw_decides_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_pull_o) && $past(!hw_en)) |-> $past(sw_ack_i));

   // R4: an automatic address acknowledge only for a matching address
   p_hw_addr_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_pull_o) && $past(hw_en) && $past(evt_is_addr_o)) |-> $past(evt_match_o));

endmodule

// File: tb/smb_slave_addr_rx_bench.sv
module smb_slave_addr_rx_bench;

   localparam int CLK_PERIOD = 10;
   localparam int QP = 6;
   localparam int HP = 12;
   localparam int NVEC = 11;

   // [31:24] address reg, [23:16] mask reg, [15:8] byte sent, [1] sw_ack, [0] expected ACK
   localparam logic [31:0] VEC [NVEC] = '{
      32'hA0_FF_A0_01,
      32'hA0_FF_A1_01,
      32'hA0_FF_A2_00,
      32'hA0_FD_A2_01,
      32'hA0_01_3C_01,
      32'hA1_FF_00_01,
      32'hA0_FF_00_00,
      32'hA1_FE_A0_00,
      32'hA0_FE_12_03,
      32'h80_81_7E_00,
      32'h80_81_C4_01
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       we_a = 1'b0;
   logic       we_m = 1'b0;
   logic       sw_ack = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       sda_pull;
   logic       sda_bus;
   logic [7:0] cfg_addr;
   logic [7:0] cfg_mask;
   logic       evt;
   logic [7:0] evt_byte;
   logic       evt_addr;
   logic       evt_match;

   int         n_checks = 0;
   int         n_fail = 0;
   int         evt_cnt = 0;
   logic [7:0] last_byte = 8'h00;
   logic       last_addr = 1'b0;
   logic       last_match = 1'b0;
   logic       done = 1'b0;

   assign sda_bus = m_sda & ~sda_pull;

   always #(CLK_PERIOD/2) clk = ~clk;

   smb_slave_addr_rx u_smb_slave_addr_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (m_scl),
      .sda_i         (sda_bus),
      .sda_pull_o    (sda_pull),
      .cfg_we_addr_i (we_a),
      .cfg_we_mask_i (we_m),
      .cfg_wdata_i   (wdata),
      .cfg_addr_o    (cfg_addr),
      .cfg_mask_o    (cfg_mask),
      .sw_ack_i      (sw_ack),
      .evt_o         (evt),
      .evt_byte_o    (evt_byte),
      .evt_is_addr_o (evt_addr),
      .evt_match_o   (evt_match)
   );

   always @(negedge clk) begin
      if (rst_n && evt) begin
         evt_cnt    <= evt_cnt + 1;
         last_byte  <= evt_byte;
         last_addr  <= evt_addr;
         last_match <= evt_match;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_cfg(input logic [7:0] a, input logic [7:0] m);
      @(negedge clk); wdata = a; we_a = 1'b1;
      @(negedge clk); we_a = 1'b0; wdata = m; we_m = 1'b1;
      @(negedge clk); we_m = 1'b0;
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wait_clk(QP);
      m_scl = 1'b1; wait_clk(HP);
      m_sda = 1'b0; wait_clk(HP);
      m_scl = 1'b0; wait_clk(QP);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wait_clk(QP);
      m_scl = 1'b1; wait_clk(HP);
      m_sda = 1'b1; wait_clk(HP);
   endtask

   task automatic bit_out(input logic b);
      m_sda = b; wait_clk(QP);
      m_scl = 1'b1; wait_clk(HP);
      m_scl = 1'b0; wait_clk(QP);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 1; i--) bit_out(b[i]);
      m_sda = b[0]; wait_clk(QP);
      m_scl = 1'b1; wait_clk(HP);
      check("R10 no drive before eighth fall", {31'd0, sda_pull}, 32'd0);
      m_scl = 1'b0; wait_clk(QP);
      m_sda = 1'b1; wait_clk(QP);
      m_scl = 1'b1; wait_clk(HP/2);
      acked = ~sda_bus;
      wait_clk(HP/2);
      m_scl = 1'b0; wait_clk(QP);
      check("R10 drive released after ninth fall", {31'd0, sda_pull}, 32'd0);
   endtask

   initial begin
      logic ack;
      int   e0;
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);

      // R1 reset state
      check("R1 address reg reset", {24'd0, cfg_addr}, 32'h00);
      check("R1 mask reg reset", {24'd0, cfg_mask}, 32'hFE);
      check("R1 SDA released", {31'd0, sda_pull}, 32'd0);

      // vector table: one address byte per transfer
      for (int v = 0; v < NVEC; v++) begin
         wr_cfg(VEC[v][31:24], VEC[v][23:16]);
         sw_ack = VEC[v][1];
         e0 = evt_cnt;
         bus_start();
         send_byte(VEC[v][15:8], ack);
         wait_clk(2);
         check("R2/R3/R4/R6/R9 address ack", {31'd0, ack}, {31'd0, VEC[v][0]});
         check("R6 one event per address", evt_cnt, e0 + 1);
         check("R6 event byte", {24'd0, last_byte}, {24'd0, VEC[v][15:8]});
         check("R6 address flag", {31'd0, last_addr}, 32'd1);
         bus_stop();
      end
      sw_ack = 1'b0;

      // R5: data bytes after a matching address in hardware mode
      wr_cfg(8'hA0, 8'hFF);
      bus_start();
      send_byte(8'hA0, ack);
      check("R4 match acked", {31'd0, ack}, 32'd1);
      foreach (VEC[k]) begin
         if (k < 3) begin
            e0 = evt_cnt;
            send_byte(VEC[k][15:8] ^ 8'h5A, ack);
            wait_clk(2);
            check("R5 data byte acked", {31'd0, ack}, 32'd1);
            check("R5 data event byte", {24'd0, last_byte}, {24'd0, VEC[k][15:8] ^ 8'h5A});
            check("R5 data flag clear", {31'd0, last_addr}, 32'd0);
            check("R5 data event count", evt_cnt, e0 + 1);
         end
      end
      bus_stop();

      // R7 then R8: non-matching address, ignored data, repeated START
      bus_start();
      send_byte(8'hA2, ack);
      check("R4 mismatch not acked", {31'd0, ack}, 32'd0);
      e0 = evt_cnt;
      send_byte(8'h55, ack);
      wait_clk(2);
      check("R7 ignored byte not acked", {31'd0, ack}, 32'd0);
      check("R7 ignored byte no event", evt_cnt, e0);
      bus_start();
      send_byte(8'hA0, ack);
      check("R8 repeated START address acked", {31'd0, ack}, 32'd1);
      bus_stop();

      // R6/R7 software mode: data NACK then ignore, STOP restarts
      wr_cfg(8'hA0, 8'hFE);
      sw_ack = 1'b1;
      bus_start();
      send_byte(8'hA6, ack);
      check("R6 software ack on address", {31'd0, ack}, 32'd1);
      sw_ack = 1'b0;
      e0 = evt_cnt;
      send_byte(8'h33, ack);
      wait_clk(2);
      check("R6 software nack on data", {31'd0, ack}, 32'd0);
      check("R6 data event raised", evt_cnt, e0 + 1);
      check("R6 data event byte", {24'd0, last_byte}, 32'h33);
      sw_ack = 1'b1;
      e0 = evt_cnt;
      send_byte(8'h44, ack);
      wait_clk(2);
      check("R7 after nack no ack", {31'd0, ack}, 32'd0);
      check("R7 after nack no event", evt_cnt, e0);
      bus_stop();
      bus_start();
      send_byte(8'h10, ack);
      check("R8 STOP restarts address reception", {31'd0, ack}, 32'd1);
      bus_stop();

      // R3/R2 match flag in software mode: general call gated off
      wr_cfg(8'hA1, 8'hFE);
      sw_ack = 1'b0;
      bus_start();
      send_byte(8'h00, ack);
      wait_clk(2);
      check("R3 general call gated by software mode", {31'd0, last_match}, 32'd0);
      bus_stop();
      bus_start();
      send_byte(8'hA1, ack);
      wait_clk(2);
      check("R2 match flag with R9 read bit", {31'd0, last_match}, 32'd1);
      check("R6 no automatic ack", {31'd0, ack}, 32'd0);
      bus_stop();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule